// File: doc/BRIEF.md
# SPI Slave Transmit Underflow Handler

This block is the transmit side of an SPI slave that runs in 3-wire mode, so no slave select line marks where a transfer starts or ends. The master's serial clock comes in asynchronously. The block passes it through a synchronizer and works in the peripheral clock domain. A transfer is a fixed count of `DATA_W` serial clock rising edges. On each rising edge the block drives one bit on MISO, most significant bit first. The master samples MISO on the falling edges.

At the first rising edge of a transfer, the state machine decides whether the word at the head of the transmit FIFO can be sent. A word qualifies only if the FIFO has reported it present for at least `LATE_WIN` peripheral clocks (3 by default) when the block registers that edge. A qualifying word is popped and shifted out. In every other case the transfer runs as an underflow and the sticky underflow flag is set.

- **Late write.** A word is present but has not been present long enough. The word stays in the FIFO for the next transfer. The first `HOLD_BITS` bits (2 by default) keep the level of the last bit of the previous transfer. The rest of the transfer drives the fill polarity.
- **Empty FIFO.** Every bit of the transfer drives the fill polarity.

The state machine has three states:

- `ST_IDLE` waits between transfers. It takes the transition *load* to `ST_SEND`, or the transition *starve* to `ST_FILL`.
- `ST_SEND` shifts the loaded word out.
- `ST_FILL` drives the hold and fill levels.

Both `ST_SEND` and `ST_FILL` take the transition *done* back to `ST_IDLE` on the rising edge that drives the last bit.

Top module: `spi_slave_tx_uf`

## Requirements
- R1: After reset, MISO is 0, the underflow flag is 0 and no pop is issued.
- R2: If the FIFO has been non-empty for at least 3 peripheral clocks when the first rising edge of a transfer is registered, the word is popped with a single one-cycle `tx_pop` pulse. The word is then driven MSB first, one bit per serial clock rising edge.
- R3: A word that has been present for fewer than 3 peripheral clocks at that edge is not popped. It is sent by the following transfer.
- R4: In the late-write case, the first 2 bits of the transfer equal the last bit driven in the previous transfer.
- R5: In the late-write case, bits 2 through `DATA_W-1` of the transfer equal `fill_pol`.
- R6: When the FIFO is empty at the first edge, every bit of the transfer equals `fill_pol`.
- R7: Any underflow transfer sets `uf_flag`. The flag stays set until `uf_clr` is pulsed high in a cycle with no new underflow.
- R8: A transfer ends after exactly `DATA_W` (default 8) rising edges. The next rising edge starts a new transfer decision.
- R9: MISO changes only after serial clock rising edges. A falling edge leaves it unchanged.
- R10: A normally loaded transfer does not set `uf_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| tx_empty | input | 1 | Transmit FIFO empty status |
| tx_data | input | DATA_W | Word at the head of the transmit FIFO |
| fill_pol | input | 1 | Level driven on MISO during underflow |
| uf_clr | input | 1 | Write-1 clear of the underflow flag |
| miso | output | 1 | Serial data to the master |
| tx_pop | output | 1 | One-cycle pop of the FIFO head word |
| uf_flag | output | 1 | Sticky underflow flag |

## Verification
The hardest situations to reach are the two sides of the late-write window. The result depends on the exact peripheral clock in which `tx_empty` falls, relative to the serial clock edge as it emerges from the synchronizer. The bench drives both inputs on peripheral clock falling edges.

- For the late case, it lowers `tx_empty` in the same cycle that it raises `sclk`. The word is then 2 cycles old at the decision.
- For the boundary case, it lowers `tx_empty` exactly one cycle earlier. The word is then 3 cycles old and sent.

The level held during the late case is checked after previous transfers that ended in 1 and in 0.

// File: rtl/spi_uf_pkg.sv
package spi_uf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_FILL = 2'd2
    } tx_state_e;
endpackage

// File: rtl/spi_uf_sclk_sync.sv
module spi_uf_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise
);
    // pipe[STAGES-1] is the synchronized clock; pipe[STAGES] is its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], sclk_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    // A detected edge lasts one peripheral cycle only
    p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/spi_uf_age.sv
module spi_uf_age #(
    parameter int LATE_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    output logic ripe
);
    localparam int AW = $clog2(LATE_WIN + 1);
    localparam logic [AW-1:0] AGE_MAX = AW'(LATE_WIN);

    logic [AW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age <= '0;
        else if (tx_empty)       age <= '0;
        else if (age != AGE_MAX) age <= age + 1'b1;
    end

    assign ripe = (age == AGE_MAX);

    p_age_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        age <= AGE_MAX);
    p_empty_unripe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |=> !ripe);
endmodule

// File: rtl/spi_uf_fsm.sv
module spi_uf_fsm
    import spi_uf_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HOLD_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              tx_empty,
    input  logic              ripe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              fill_pol,
    input  logic              uf_clr,
    output logic              miso,
    output logic              tx_pop,
    output logic              uf_flag
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

    tx_state_e         state, state_nxt;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] shreg;
    logic              late_q;
    logic              go;
    logic              in_hold;

    assign go      = !tx_empty && ripe;
    assign in_hold = late_q && (int'(cnt) < HOLD_BITS);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (rise) state_nxt = go ? ST_SEND : ST_FILL;
            ST_SEND: if (rise && cnt == LAST_IDX) state_nxt = ST_IDLE;
            ST_FILL: if (rise && cnt == LAST_IDX) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso    <= 1'b0;
            tx_pop  <= 1'b0;
            uf_flag <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
            late_q  <= 1'b0;
        end else begin
            tx_pop <= 1'b0;
            if (rise && state == ST_IDLE && !go) uf_flag <= 1'b1;
            else if (uf_clr)                     uf_flag <= 1'b0;
            if (rise) begin
                unique case (state)
                    ST_IDLE: begin
                        cnt <= CW'(1);
                        if (go) begin
                            miso   <= tx_data[DATA_W-1];
                            shreg  <= tx_data << 1;
                            tx_pop <= 1'b1;
                            late_q <= 1'b0;
                        end else begin
                            late_q <= !tx_empty;
                            if (tx_empty || HOLD_BITS == 0) miso <= fill_pol;
                        end
                    end
                    ST_SEND: begin
                        miso  <= shreg[DATA_W-1];
                        shreg <= shreg << 1;
                        cnt   <= cnt + 1'b1;
                    end
                    ST_FILL: begin
                        if (!in_hold) miso <= fill_pol;
                        cnt <= cnt + 1'b1;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> $past(!tx_empty));
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !uf_clr) |=> uf_flag);
    p_no_pop_on_uf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf_flag) |-> !tx_pop);
    p_hold_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state == ST_FILL && in_hold) |=> $stable(miso));
    p_fill_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && state == ST_FILL && !in_hold) |=> (miso == $past(fill_pol)));
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(miso));
endmodule

// File: rtl/spi_slave_tx_uf.sv
module spi_slave_tx_uf #(
    parameter int DATA_W      = 8,
    parameter int LATE_WIN    = 3,
    parameter int HOLD_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              fill_pol,
    input  logic              uf_clr,
    output logic              miso,
    output logic              tx_pop,
    output logic              uf_flag
);
    logic sclk_rise;
    logic word_ripe;

    spi_uf_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk),
        .rise    (sclk_rise)
    );

    spi_uf_age #(.LATE_WIN(LATE_WIN)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .ripe     (word_ripe)
    );

    spi_uf_fsm #(.DATA_W(DATA_W), .HOLD_BITS(HOLD_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (sclk_rise),
        .tx_empty (tx_empty),
        .ripe     (word_ripe),
        .tx_data  (tx_data),
        .fill_pol (fill_pol),
        .uf_clr   (uf_clr),
        .miso     (miso),
        .tx_pop   (tx_pop),
        .uf_flag  (uf_flag)
    );
endmodule

// File: tb/spi_slave_tx_uf_tb.sv
module spi_slave_tx_uf_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         tx_empty = 1'b1;
    logic [W-1:0] tx_data = '0;
    logic         fill_pol = 1'b0;
    logic         uf_clr = 1'b0;
    logic         miso, tx_pop, uf_flag;

    int tests = 0;
    int fails = 0;
    int pops  = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    spi_slave_tx_uf #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .tx_empty(tx_empty),
        .tx_data(tx_data), .fill_pol(fill_pol), .uf_clr(uf_clr),
        .miso(miso), .tx_pop(tx_pop), .uf_flag(uf_flag)
    );

    always @(negedge clk) if (tx_pop) pops++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One transfer of W serial clock cycles, called at a peripheral falling edge
    task automatic xfer(output logic [W-1:0] got);
        logic quiet = 1'b1;
        got = '0;
        for (int i = 0; i < W; i++) begin
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            got[W-1-i] = miso;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            if (miso !== got[W-1-i]) quiet = 1'b0;
        end
        check("R9 falling edge leaves miso", {31'd0, quiet}, 32'd1);
    endtask

    task automatic clear_flag();
        @(negedge clk) uf_clr = 1'b1;
        @(negedge clk) uf_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 miso after reset", {31'd0, miso}, 32'd0);
        check("R1 flag after reset", {31'd0, uf_flag}, 32'd0);
        check("R1 no pop after reset", pops, 0);
    endtask

    task automatic t_normal(input logic [W-1:0] word);
        logic [W-1:0] got;
        int p0 = pops;
        logic f0 = uf_flag;
        tx_data = word; tx_empty = 1'b0;
        repeat (10) @(negedge clk);
        xfer(got);
        check("R2 word sent MSB first", got, word);
        check("R2 single pop", pops - p0, 1);
        check("R10 flag unchanged by normal transfer", {31'd0, uf_flag}, {31'd0, f0});
        tx_empty = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_late(input logic [W-1:0] word, input logic pol, input logic prev_last);
        logic [W-1:0] got;
        int p0 = pops;
        fill_pol = pol; tx_data = word;
        @(negedge clk);
        tx_empty = 1'b0;
        xfer(got);
        check("R4 first two bits hold last level", {30'd0, got[W-1 -: 2]}, {30'd0, {2{prev_last}}});
        check("R5 remaining bits at fill level", {26'd0, got[W-3:0]}, {26'd0, {(W-2){pol}}});
        check("R3 late word not popped", pops - p0, 0);
        check("R7 flag set by late write", {31'd0, uf_flag}, 32'd1);
    endtask

    task automatic t_deferred(input logic [W-1:0] word);
        logic [W-1:0] got;
        int p0 = pops;
        clear_flag();
        @(negedge clk);
        check("R7 flag cleared by write-1", {31'd0, uf_flag}, 32'd0);
        xfer(got);
        check("R3 deferred word sent next (R8 boundary)", got, word);
        check("R3 deferred word popped", pops - p0, 1);
        check("R10 no flag on deferred send", {31'd0, uf_flag}, 32'd0);
        tx_empty = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_empty(input logic pol);
        logic [W-1:0] got;
        fill_pol = pol; tx_empty = 1'b1;
        @(negedge clk);
        xfer(got);
        check("R6 empty transfer at fill level", got, {W{pol}});
        check("R7 flag set by empty transfer", {31'd0, uf_flag}, 32'd1);
    endtask

    task automatic t_boundary(input logic [W-1:0] word);
        logic [W-1:0] got;
        int p0 = pops;
        clear_flag();
        tx_data = word; tx_empty = 1'b0;
        @(negedge clk);
        xfer(got);
        check("R2 word at exactly 3 cycles is sent", got, word);
        check("R2 boundary pop", pops - p0, 1);
        check("R10 boundary no flag", {31'd0, uf_flag}, 32'd0);
        tx_empty = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_normal(8'hA5);
        t_late(8'h3C, 1'b0, 1'b1);
        t_deferred(8'h3C);
        t_late(8'h96, 1'b1, 1'b0);
        tx_empty = 1'b1;
        t_normal(8'h5A);
        check("R7 flag sticky across normal transfer", {31'd0, uf_flag}, 32'd1);
        clear_flag();
        t_empty(1'b1);
        t_empty(1'b0);
        t_boundary(8'hC3);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule